// File: doc/BRIEF.md
# SD Command Token Engine

This block sends one command token on the single-bit command line of an SD card and then collects the card's reply. A client offers a request through a valid/ready handshake. The request holds a 6-bit command index, a 32-bit argument and a reply-kind selector. The engine drives a 48-bit token out one bit per card clock, most significant bit first. It works out the 7-bit checksum while the first 40 bits leave, so no cycle is spent precomputing it. It then releases the line and listens for the card's start bit. Once it finds that bit, it shifts in a 48-bit or 136-bit reply. It ends each request with a one-cycle result pulse, or with a one-cycle timeout pulse if the card stays silent.

The control is one state machine with six states. IDLE waits for a request and moves to SEND when one is accepted. SEND drives the 48 token bits. After the last bit it moves to DONE if no reply is expected, and to LISTEN otherwise. LISTEN samples the released line. It moves to CAPTURE on the first low bit, or to EXPIRED when 64 listening cycles pass without one. CAPTURE shifts in the rest of the reply and moves to DONE after the last bit. DONE pulses the result and EXPIRED pulses the timeout. Both return to IDLE on the next clock.

Top module: `sd_cmd_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, cmd_oe is 0, cmd_out is 1, and rsp_valid and rsp_timeout are both 0.
- R2: A request is taken only when req_valid and req_ready are both high at a clock edge. req_ready is low from the cycle after acceptance through the report cycle. It is high again in the cycle after the report. req_valid and the request fields have no effect while req_ready is low.
- R3: In the 48 cycles after acceptance, cmd_out carries token bit k in cycle k (k = 0..47), most significant bit first. Bits 0 and 1 are 0 then 1. Bits 2..7 are the command index, MSB first. Bits 8..39 are the argument, MSB first.
- R4: Token bits 40..46 are a CRC7, MSB first. It uses the polynomial x^7 + x^3 + 1 with an all-zero start value, taken over token bits 0..39. For example, index 0 with argument 0 gives 0x4A.
- R5: Token bit 47 is 1. cmd_oe is high in exactly the 48 token cycles. At every other time cmd_oe is 0 and cmd_out is 1.
- R6: req_rsp encodes the reply kind: 00 means no reply, 01 means a 48-bit reply, and 10 or 11 means a 136-bit reply. With no reply, rsp_valid pulses in cycle 48 and rsp_data is all zero.
- R7: Listening starts in cycle 48. The start bit is the first 0 sampled on cmd_in while listening. Values on cmd_in during the token cycles are ignored.
- R8: For a 48-bit reply, the start bit and the 47 bits after it appear in rsp_data[47:0], first bit at position 47, and rsp_data[135:48] is zero. If the start bit is sampled in listening cycle d, rsp_valid pulses in cycle 48+d+48.
- R9: For a 136-bit reply, all 136 bits, start bit first at position 135, appear in rsp_data, including the card's own checksum. rsp_valid pulses in cycle 48+d+136.
- R10: If cmd_in stays 1 for all 64 listening cycles, rsp_timeout pulses for one cycle in cycle 112 and rsp_valid stays low. A start bit in listening cycle 63 is still taken as a reply.
- R11: rsp_data keeps the reported value unchanged until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one command-line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp | input | 2 | Reply kind: 00 none, 01 48-bit, 1x 136-bit |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Command-line drive enable |
| cmd_in | input | 1 | Sampled command-line value |
| rsp_valid | output | 1 | One-cycle pulse: request finished, rsp_data valid |
| rsp_timeout | output | 1 | One-cycle pulse: no start bit within 64 cycles |
| rsp_data | output | 136 | Captured reply, right-aligned |

## Verification
The sweep walks every command index with varied arguments and all three reply kinds, and compares every token bit against a checksum computed in the bench. The bench's checksum is first tied to known tokens, so a wrong polynomial, a nonzero start value or an off-by-one in the CRC window shows up as miscompared bits 40..46. The listening window is probed at start delays 0, 1, 62 and 63, and at a silent line. A counter that is one cycle short or long either drops a valid reply or misses the timeout in cycle 112. Low bits placed on the line during the token, and requests held asserted while busy, catch an engine that listens too early or re-accepts mid-transfer. Checks of the reply's position and its hold through the following idle cycle catch shifting errors between the 48-bit and 136-bit paths.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_LISTEN,
        ST_CAPTURE,
        ST_DONE,
        ST_EXPIRED
    } sd_state_e;

    typedef enum logic [1:0] {
        RSP_NONE     = 2'b00,
        RSP_SHORT    = 2'b01,
        RSP_LONG     = 2'b10,
        RSP_LONG_ALT = 2'b11
    } rsp_kind_e;

    // x^7 + x^3 + 1 without the x^7 term
    localparam logic [6:0] CRC7_POLY = 7'h09;

endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
    parameter int               CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY  = 7'h09
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic shift,
    input  logic din,
    output logic crc_msb
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clear) begin
            crc_q <= '0;
        end else if (step) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ ((din ^ crc_q[CRC_W-1]) ? POLY : '0);
        end else if (shift) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    assign crc_msb = crc_q[CRC_W-1];

    // R4
    crc_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == '0));

    // R4
    crc_mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && shift));

endmodule

// File: rtl/sd_cmd_tx_shift.sv
module sd_cmd_tx_shift #(
    parameter int TOKEN_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TOKEN_W-1:0] load_val,
    input  logic               shift,
    output logic               msb
);

    logic [TOKEN_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[TOKEN_W-2:0], 1'b1};
        end
    end

    assign msb = sh_q[TOKEN_W-1];

    // R3
    tx_load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/sd_cmd_rx_capture.sv
module sd_cmd_rx_capture #(
    parameter int LONG_W = 136
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              din,
    output logic [LONG_W-1:0] data
);

    logic [LONG_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (clear) begin
            cap_q <= '0;
        end else if (shift) begin
            cap_q <= {cap_q[LONG_W-2:0], din};
        end
    end

    assign data = cap_q;

    // R11
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift) |=> $stable(cap_q));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int IDX_W          = 6,
    parameter int ARG_W          = 32,
    parameter int CRC_W          = 7,
    parameter int SHORT_W        = 48,
    parameter int LONG_W         = 136,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [ARG_W-1:0]  req_arg,
    input  logic [1:0]        req_rsp,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in,
    output logic              rsp_valid,
    output logic              rsp_timeout,
    output logic [LONG_W-1:0] rsp_data
);

    localparam int TOKEN_W   = 3 + IDX_W + ARG_W + CRC_W;
    localparam int PAYLOAD_W = TOKEN_W - CRC_W - 1;
    localparam int TX_CW     = $clog2(TOKEN_W);
    localparam int RX_CW     = $clog2(LONG_W);
    localparam int WAIT_CW   = $clog2(TIMEOUT_CYCLES);

    localparam logic [TX_CW-1:0]   TX_PAY_END  = TX_CW'(PAYLOAD_W);
    localparam logic [TX_CW-1:0]   TX_LAST     = TX_CW'(TOKEN_W - 1);
    localparam logic [RX_CW-1:0]   RX_SHORT_LAST = RX_CW'(SHORT_W - 1);
    localparam logic [RX_CW-1:0]   RX_LONG_LAST  = RX_CW'(LONG_W - 1);
    localparam logic [WAIT_CW-1:0] WAIT_LAST   = WAIT_CW'(TIMEOUT_CYCLES - 1);

    sd_state_e          state_q, state_nx;
    logic [TX_CW-1:0]   tx_cnt_q;
    logic [RX_CW-1:0]   rx_cnt_q;
    logic [WAIT_CW-1:0] wait_cnt_q;
    logic               none_q;
    logic               long_q;

    logic               accept;
    logic               in_send, in_listen, in_capture;
    logic               start_seen;
    logic               tx_msb, crc_msb;
    logic               crc_step, crc_shift;
    logic               rx_shift;
    logic [RX_CW-1:0]   rx_last;
    logic [TOKEN_W-1:0] frame;

    assign in_send    = (state_q == ST_SEND);
    assign in_listen  = (state_q == ST_LISTEN);
    assign in_capture = (state_q == ST_CAPTURE);
    assign accept     = req_valid && (state_q == ST_IDLE);
    assign start_seen = in_listen && !cmd_in;
    assign rx_last    = long_q ? RX_LONG_LAST : RX_SHORT_LAST;
    assign frame      = {2'b01, req_index, req_arg, {CRC_W{1'b0}}, 1'b1};

    assign crc_step  = in_send && (tx_cnt_q < TX_PAY_END);
    assign crc_shift = in_send && (tx_cnt_q >= TX_PAY_END) && (tx_cnt_q != TX_LAST);
    assign rx_shift  = start_seen || in_capture;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_nx = ST_SEND;
            end
            ST_SEND: begin
                if (tx_cnt_q == TX_LAST) state_nx = none_q ? ST_DONE : ST_LISTEN;
            end
            ST_LISTEN: begin
                if (!cmd_in)                      state_nx = ST_CAPTURE;
                else if (wait_cnt_q == WAIT_LAST) state_nx = ST_EXPIRED;
            end
            ST_CAPTURE: begin
                if (rx_cnt_q == rx_last) state_nx = ST_DONE;
            end
            ST_DONE:    state_nx = ST_IDLE;
            ST_EXPIRED: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // ---------------- counters and request latch ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt_q   <= '0;
            rx_cnt_q   <= '0;
            wait_cnt_q <= '0;
            none_q     <= 1'b0;
            long_q     <= 1'b0;
        end else begin
            if (accept) begin
                none_q <= (req_rsp == RSP_NONE);
                long_q <= req_rsp[1];
            end

            if (in_send) tx_cnt_q <= tx_cnt_q + 1'b1;
            else         tx_cnt_q <= '0;

            if (in_listen) wait_cnt_q <= wait_cnt_q + 1'b1;
            else           wait_cnt_q <= '0;

            if (start_seen)      rx_cnt_q <= RX_CW'(1);
            else if (in_capture) rx_cnt_q <= rx_cnt_q + 1'b1;
        end
    end

    // ---------------- datapath pieces ----------------
    sd_cmd_tx_shift #(
        .TOKEN_W (TOKEN_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (frame),
        .shift    (in_send),
        .msb      (tx_msb)
    );

    sd_crc7 #(
        .CRC_W (CRC_W),
        .POLY  (CRC7_POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (crc_step),
        .shift   (crc_shift),
        .din     (tx_msb),
        .crc_msb (crc_msb)
    );

    sd_cmd_rx_capture #(
        .LONG_W (LONG_W)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .shift (rx_shift),
        .din   (cmd_in),
        .data  (rsp_data)
    );

    // ---------------- outputs ----------------
    always_comb begin
        req_ready   = 1'b0;
        cmd_oe      = 1'b0;
        cmd_out     = 1'b1;
        rsp_valid   = 1'b0;
        rsp_timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SEND: begin
                cmd_oe = 1'b1;
                if (tx_cnt_q < TX_PAY_END)  cmd_out = tx_msb;
                else if (tx_cnt_q != TX_LAST) cmd_out = crc_msb;
                else                          cmd_out = 1'b1;
            end
            ST_LISTEN:  ;
            ST_CAPTURE: ;
            ST_DONE:    rsp_valid   = 1'b1;
            ST_EXPIRED: rsp_timeout = 1'b1;
            default:    ;
        endcase
    end

    // ---------------- assertions ----------------
    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_oe && !cmd_out));

    // R5
    released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);

    // R5
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));

    // R6
    report_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_timeout));

    // R2
    report_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rsp_timeout) |=> (req_ready && !rsp_valid && !rsp_timeout));

    // R7
    start_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_listen && !cmd_in) |=> (state_q == ST_CAPTURE));

    // R10
    timeout_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_timeout) |-> $past(cmd_in));

endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic [1:0]   req_rsp;
    logic         cmd_out;
    logic         cmd_oe;
    logic         cmd_in;
    logic         rsp_valid;
    logic         rsp_timeout;
    logic [135:0] rsp_data;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sd_cmd_engine u_sd_cmd_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_index   (req_index),
        .req_arg     (req_arg),
        .req_rsp     (req_rsp),
        .cmd_out     (cmd_out),
        .cmd_oe      (cmd_oe),
        .cmd_in      (cmd_in),
        .rsp_valid   (rsp_valid),
        .rsp_timeout (rsp_timeout),
        .rsp_data    (rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [135:0] act, input logic [135:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_of(input logic [39:0] v);
        logic [6:0] c = 7'h00;
        for (int i = 39; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // One full request; cycle c counts from 0 = first cycle after acceptance
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [1:0] kind, input int delay,
                           input bit noise, input bit poke);
        logic [47:0]  tok;
        logic [135:0] rb;
        int           len;
        int           report_c;
        bit           tmo;
        string        tag;

        tok = {2'b01, idx, arg, crc7_of({2'b01, idx, arg}), 1'b1};
        len = (kind == 2'b00) ? 0 : (kind == 2'b01) ? 48 : 136;
        rb  = '0;
        for (int i = 0; i < len; i++) rb[i] = 1'($urandom_range(0, 1));
        if (len > 0) rb[len-1] = 1'b0;
        tmo      = (len > 0) && (delay >= 64);
        report_c = (len == 0) ? 48 : tmo ? 112 : 48 + delay + len;

        @(negedge clk);
        req_valid = 1'b1;
        req_index = idx;
        req_arg   = arg;
        req_rsp   = kind;
        cmd_in    = 1'b1;
        @(posedge clk);

        for (int c = 0; c <= report_c + 1; c++) begin
            @(negedge clk);
            if (poke) begin
                req_valid = (c < report_c);
                req_index = ~idx;
                req_arg   = ~arg;
                req_rsp   = ~kind;
            end else begin
                req_valid = 1'b0;
            end

            if (c < 48) begin
                tag = (c < 40) ? "R3" : (c < 47) ? "R4" : "R5";
                chk(cmd_oe === 1'b1 && cmd_out === tok[47-c], tag, "token bit",
                    {cmd_oe, cmd_out}, {1'b1, tok[47-c]});
            end else begin
                chk(cmd_oe === 1'b0 && cmd_out === 1'b1, "R5", "line released",
                    {cmd_oe, cmd_out}, 2'b01);
            end

            chk(req_ready === (c == report_c + 1), "R2", "ready", req_ready,
                (c == report_c + 1));
            tag = (len == 0) ? "R6" : (len == 48) ? "R8" : "R9";
            chk(rsp_valid === (c == report_c && !tmo), tag, "rsp_valid", rsp_valid,
                (c == report_c && !tmo));
            chk(rsp_timeout === (c == report_c && tmo), "R10", "rsp_timeout", rsp_timeout,
                (c == report_c && tmo));
            if (c == report_c && !tmo)
                chk(rsp_data === rb, tag, "reply data", rsp_data, rb);
            if (c == report_c + 1 && !tmo)
                chk(rsp_data === rb, "R11", "reply held", rsp_data, rb);

            // R7: noise during the token must be ignored
            if (c < 48) begin
                cmd_in = noise ? ((c % 3) != 0) : 1'b1;
            end else if (len > 0 && (c - 48) >= delay && (c - 48 - delay) < len) begin
                cmd_in = rb[len - 1 - (c - 48 - delay)];
            end else begin
                cmd_in = 1'b1;
            end
        end
        req_valid = 1'b0;
        cmd_in    = 1'b1;
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_index = '0;
        req_arg   = '0;
        req_rsp   = '0;
        cmd_in    = 1'b1;

        repeat (3) @(negedge clk);
        // R1 during reset
        chk(req_ready === 1'b1 && cmd_oe === 1'b0 && cmd_out === 1'b1 &&
            rsp_valid === 1'b0 && rsp_timeout === 1'b0, "R1", "reset outputs",
            {req_ready, cmd_oe, cmd_out, rsp_valid, rsp_timeout}, 5'b10100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && cmd_oe === 1'b0 && cmd_out === 1'b1 &&
            rsp_valid === 1'b0 && rsp_timeout === 1'b0, "R1", "after reset",
            {req_ready, cmd_oe, cmd_out, rsp_valid, rsp_timeout}, 5'b10100);

        // R4 anchors for the bench checksum
        chk(crc7_of(40'h40_0000_0000) === 7'h4A, "R4", "crc anchor idx0",
            crc7_of(40'h40_0000_0000), 7'h4A);
        chk(crc7_of(40'h51_0000_0000) === 7'h2A, "R4", "crc anchor idx17",
            crc7_of(40'h51_0000_0000), 7'h2A);
        chk(crc7_of(40'h48_0000_01AA) === 7'h43, "R4", "crc anchor idx8",
            crc7_of(40'h48_0000_01AA), 7'h43);

        // sweep every index, all reply kinds, short delays
        for (int i = 0; i < 64; i++) begin
            run_cmd(6'(i), (32'h9E37_79B9 * i) ^ 32'h0000_01AA, 2'(i % 3),
                    i % 5, (i % 2) == 1, 1'b0);
        end
        run_cmd(6'd41, 32'hFFFF_FFFF, 2'b11, 2, 1'b0, 1'b0); // R6 alt long code

        // R10 window boundaries
        run_cmd(6'd17, 32'h0000_0000, 2'b01, 0,  1'b0, 1'b0);
        run_cmd(6'd17, 32'h1234_5678, 2'b01, 1,  1'b1, 1'b0);
        run_cmd(6'd13, 32'hA5A5_5A5A, 2'b01, 62, 1'b0, 1'b0);
        run_cmd(6'd13, 32'h0F0F_F0F0, 2'b01, 63, 1'b0, 1'b0);
        run_cmd(6'd55, 32'h8000_0001, 2'b01, 64, 1'b0, 1'b0);
        run_cmd(6'd2,  32'h0000_0000, 2'b10, 63, 1'b1, 1'b0);
        run_cmd(6'd9,  32'hDEAD_BEEF, 2'b10, 64, 1'b0, 1'b0);
        run_cmd(6'd2,  32'hCAFE_F00D, 2'b10, 0,  1'b0, 1'b0);

        // R2 requests held while busy
        run_cmd(6'd7,  32'h0102_0304, 2'b01, 3, 1'b0, 1'b1);
        run_cmd(6'd0,  32'h0000_0000, 2'b00, 0, 1'b1, 1'b1);
        run_cmd(6'd3,  32'h7777_0000, 2'b10, 5, 1'b1, 1'b1);

        // line stays released in idle
        repeat (4) begin
            @(negedge clk);
            chk(cmd_oe === 1'b0 && cmd_out === 1'b1 && req_ready === 1'b1, "R5",
                "idle release", {cmd_oe, cmd_out, req_ready}, 3'b011);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule